// File: doc/BRIEF.md
# Character-Synchronous Serial Transceiver with Sync Hunt

This block is one full-duplex channel for character-oriented synchronous links. There is no start or stop framing on the line. The transmitter serialises host characters, one bit per transmit tick, least significant bit first. When the host has no character waiting, the transmitter fills the line with the programmed sync characters, so the far end never loses character alignment.

The receiver starts in hunt. In hunt it compares the most recent line bits against the sync pattern after every received bit. The pattern is either one framed sync character, or two framed sync characters in a row. In external mode the receiver instead locks on a dedicated sync input. Once locked, the receiver cuts the bit stream into characters whose boundaries are fixed relative to the pattern. It stays locked until the host commands a new hunt.

Both directions hold one character in a holding buffer next to the shifter. The host sees ready and empty flags and sees the received character together with its parity and overrun status. Bit timing comes from two single-cycle tick inputs, and the configuration inputs are expected to stay stable outside reset.

Top module: `bisync_xcvr`

## Requirements
- R1: A character carries 5 + `cfg_len` data bits (`cfg_len` 0..3 gives 5..8). On `tx_sd` each character goes out least significant bit first, one bit per `tx_tick`, with no gaps between characters. The first character after reset starts at the first tick.
- R2: With `cfg_par_en` = 1, one parity bit follows the data bits. It makes the count of ones over data plus parity even when `cfg_par_odd` = 0, and odd when `cfg_par_odd` = 1. With `cfg_par_en` = 0 no parity bit is sent or expected.
- R3: At a character boundary with no host character waiting, the transmitter sends `cfg_sync1` (framed as in R1/R2). With `cfg_two_sync` = 1, every fill `cfg_sync1` is followed directly by a fill `cfg_sync2`, even if host data arrives in between. `tx_empty` is 1 exactly when the shifter holds a fill character and the holding buffer is empty.
- R4: `tx_ready` is 1 while the holding buffer is empty. A `tx_wr` while `tx_ready` = 1 stores `tx_wdata` and drops `tx_ready` in the next cycle. A `tx_wr` while `tx_ready` = 0 is ignored. The buffer empties when the shifter takes its character at a boundary.
- R5: With `cfg_ext_sync` = 0 and `cfg_two_sync` = 0, the receiver locks on the `rx_tick` that completes a framed `cfg_sync1` in the last received bits. `sync_det` is 1 from the following cycle.
- R6: With `cfg_two_sync` = 1, lock needs a framed `cfg_sync1` immediately followed by a framed `cfg_sync2`. A `cfg_sync1` alone does not lock.
- R7: After lock, each group of (data + parity) bits starting with the bit after the pattern forms one character. On the tick of its last bit the data is placed right-aligned, zero-extended, on `rx_rdata` and `rx_ready` rises in the next cycle. All characters, sync characters included, are delivered.
- R8: `par_err` accompanies each delivered character. It is 1 when parity is enabled and the received parity does not meet R2.
- R9: A character completing while `rx_ready` = 1 and `rx_rd` = 0 sets `ovr_err` and replaces the buffered data. `rx_rd` clears `rx_ready`, `par_err` and `ovr_err` in the next cycle, unless a character completes in the same cycle.
- R10: With `cfg_ext_sync` = 1, pattern matching is off. An `ext_sync` = 1 on an `rx_tick` during hunt locks the receiver, and the bit sampled on that tick is bit 0 of the first character.
- R11: Once locked, `sync_det` stays 1 whatever the line carries until `hunt_cmd`. `hunt_cmd` clears `sync_det` in the next cycle and restarts the hunt.
- R12: Synchronous active-low reset leaves `tx_ready` = 1, `tx_empty` = 1, `tx_sd` = 1, and `rx_ready`, `sync_det`, `par_err` and `ovr_err` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_len | input | 2 | Data bits minus five |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_two_sync | input | 1 | Pattern is two sync characters |
| cfg_ext_sync | input | 1 | Lock on `ext_sync` instead of pattern |
| cfg_sync1 | input | 8 | First sync character |
| cfg_sync2 | input | 8 | Second sync character |
| tx_tick | input | 1 | Transmit bit strobe |
| tx_wr | input | 1 | Host write strobe |
| tx_wdata | input | 8 | Character to send |
| tx_ready | output | 1 | Transmit holding buffer free |
| tx_empty | output | 1 | Sending fill with nothing queued |
| tx_sd | output | 1 | Serial transmit line |
| rx_tick | input | 1 | Receive bit strobe |
| rx_sd | input | 1 | Serial receive line |
| ext_sync | input | 1 | External lock request |
| hunt_cmd | input | 1 | Drop lock and hunt again |
| rx_rd | input | 1 | Host read strobe |
| rx_rdata | output | 8 | Received character |
| rx_ready | output | 1 | Received character waiting |
| sync_det | output | 1 | Receiver locked |
| par_err | output | 1 | Parity fault on buffered character |
| ovr_err | output | 1 | Character lost to overrun |

## Verification
Each transmit bit is on `tx_sd` one cycle after its tick. The bench therefore samples the line on the falling edge after each tick and decodes characters at fixed offsets from the first tick after reset. Lock and character delivery are registered once on the receive tick, so `sync_det`, `rx_ready`, `rx_rdata`, `par_err` and `ovr_err` are due one cycle after the deciding tick. Directed receive bits are sent one per task call and checked on the falling edge that ends that call. Write acceptance and read clearing are due one cycle after the strobe and are checked on the next falling edge.

// File: rtl/bsx_pkg.sv
// Shared constants and framing helpers for the synchronous transceiver.
// Assumes characters of LEN_MIN..CHAR_MAX bits plus an optional parity bit.
package bsx_pkg;
    localparam int CHAR_MAX = 8;
    localparam int LEN_MIN  = 5;
    localparam int LEN_W    = $clog2(CHAR_MAX - LEN_MIN + 1);
    localparam int FRM_MAX  = CHAR_MAX + 1;
    localparam int HIST_LEN = 2 * FRM_MAX;
    localparam int CNT_W    = $clog2(FRM_MAX + 1);

    // number of data bits for a length code
    function automatic logic [CNT_W-1:0] data_bits(input logic [LEN_W-1:0] len);
        return CNT_W'(LEN_MIN) + CNT_W'(len);
    endfunction

    // number of line bits per character
    function automatic logic [CNT_W-1:0] frame_bits(input logic [LEN_W-1:0] len,
                                                    input logic par_en);
        return data_bits(len) + CNT_W'(par_en);
    endfunction

    // mask keeping only the data bits
    function automatic logic [FRM_MAX-1:0] data_mask(input logic [LEN_W-1:0] len);
        return (FRM_MAX'(1) << data_bits(len)) - FRM_MAX'(1);
    endfunction

    // character as it appears on the line, bit 0 sent first
    function automatic logic [FRM_MAX-1:0] build_frame(input logic [CHAR_MAX-1:0] d,
                                                       input logic [LEN_W-1:0] len,
                                                       input logic par_en,
                                                       input logic par_odd);
        logic [FRM_MAX-1:0] body;
        logic               p;
        body = FRM_MAX'(d) & data_mask(len);
        p    = (^body) ^ par_odd;
        return par_en ? (body | (FRM_MAX'(p) << data_bits(len))) : body;
    endfunction
endpackage

// File: rtl/bsx_tx.sv
// Transmit half: holding buffer, shifter and idle sync fill.
// Assumes tick is a one-cycle strobe and configuration is static outside reset.
module bsx_tx
    import bsx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic                cfg_two_sync,
    input  logic [CHAR_MAX-1:0] cfg_sync1,
    input  logic [CHAR_MAX-1:0] cfg_sync2,
    input  logic                tick,
    input  logic                wr,
    input  logic [CHAR_MAX-1:0] wdata,
    output logic                ready,
    output logic                empty,
    output logic                sd
);
    logic                hold_full;
    logic [CHAR_MAX-1:0] hold_q;
    logic [FRM_MAX-1:0]  shf_q;
    logic [CNT_W-1:0]    left_q;
    logic                fill_q;
    logic                pend2_q;
    logic                sd_q;

    logic [FRM_MAX-1:0]  pick_frame;
    logic                pick_fill;
    logic                pick_pend2;
    logic [CNT_W-1:0]    nbits;
    logic                load;

    assign nbits = frame_bits(cfg_len, cfg_par_en);
    assign load  = tick && (left_q == '0);

    // choose the next character: pending second sync, host data, or fill
    always_comb begin
        pick_frame = build_frame(cfg_sync1, cfg_len, cfg_par_en, cfg_par_odd);
        pick_fill  = 1'b1;
        pick_pend2 = cfg_two_sync;
        if (pend2_q) begin
            pick_frame = build_frame(cfg_sync2, cfg_len, cfg_par_en, cfg_par_odd);
            pick_pend2 = 1'b0;
        end else if (hold_full) begin
            pick_frame = build_frame(hold_q, cfg_len, cfg_par_en, cfg_par_odd);
            pick_fill  = 1'b0;
            pick_pend2 = 1'b0;
        end
    end

    // shifter: load at a boundary, otherwise shift one bit per tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shf_q   <= '0;
            left_q  <= '0;
            fill_q  <= 1'b1;
            pend2_q <= 1'b0;
            sd_q    <= 1'b1;
        end else if (tick) begin
            if (left_q == '0) begin
                sd_q    <= pick_frame[0];
                shf_q   <= pick_frame >> 1;
                left_q  <= nbits - CNT_W'(1);
                fill_q  <= pick_fill;
                pend2_q <= pick_pend2;
            end else begin
                sd_q   <= shf_q[0];
                shf_q  <= shf_q >> 1;
                left_q <= left_q - CNT_W'(1);
            end
        end
    end

    // holding buffer: filled by the host, drained by the shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_q    <= '0;
        end else if (load && !pend2_q && hold_full) begin
            hold_full <= 1'b0;
        end else if (wr && !hold_full) begin
            hold_full <= 1'b1;
            hold_q    <= wdata;
        end
    end

    assign ready = !hold_full;
    assign empty = fill_q && !hold_full;
    assign sd    = sd_q;
endmodule

// File: rtl/bsx_sync_match.sv
// Compares the newest line bits with the one- or two-character sync pattern.
// Assumes hist holds the newest bit in its top position.
module bsx_sync_match
    import bsx_pkg::*;
(
    input  logic [HIST_LEN-1:0] hist,
    input  logic [CNT_W-1:0]    fbits,
    input  logic                two,
    input  logic [FRM_MAX-1:0]  fr1,
    input  logic [FRM_MAX-1:0]  fr2,
    output logic                hit
);
    int                  sh1;
    int                  sh2;
    logic [HIST_LEN-1:0] win1;
    logic [HIST_LEN-1:0] win2;
    logic [HIST_LEN-1:0] pair;

    // align the newest one or two characters and compare
    always_comb begin
        sh1  = HIST_LEN - int'(fbits);
        sh2  = HIST_LEN - 2 * int'(fbits);
        win1 = hist >> sh1;
        win2 = hist >> sh2;
        pair = (HIST_LEN'(fr2) << fbits) | HIST_LEN'(fr1);
        hit  = two ? (win2 == pair) : (win1 == HIST_LEN'(fr1));
    end
endmodule

// File: rtl/bsx_rx.sv
// Receive half: bitwise hunt, lock, character assembly, parity and overrun.
// Assumes tick is a one-cycle strobe and configuration is static outside reset.
module bsx_rx
    import bsx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic                cfg_two_sync,
    input  logic                cfg_ext_sync,
    input  logic [CHAR_MAX-1:0] cfg_sync1,
    input  logic [CHAR_MAX-1:0] cfg_sync2,
    input  logic                tick,
    input  logic                sd,
    input  logic                ext_sync,
    input  logic                hunt,
    input  logic                rd,
    output logic [CHAR_MAX-1:0] rdata,
    output logic                ready,
    output logic                locked,
    output logic                perr,
    output logic                ovr,
    output logic                char_done
);
    logic [HIST_LEN-1:0] hist_q;
    logic [HIST_LEN-1:0] hist_n;
    logic [HIST_LEN-1:0] win_f;
    logic [FRM_MAX-1:0]  got;
    logic                locked_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CHAR_MAX-1:0] buf_q;
    logic                rdy_q;
    logic                perr_q;
    logic                ovr_q;
    logic [CNT_W-1:0]    fbits;
    logic                hit;
    logic                lock_now;

    assign fbits    = frame_bits(cfg_len, cfg_par_en);
    assign hist_n   = {sd, hist_q[HIST_LEN-1:1]};
    assign win_f    = hist_n >> (HIST_LEN - int'(fbits));
    assign got      = win_f[FRM_MAX-1:0];
    assign lock_now = cfg_ext_sync ? ext_sync : hit;
    assign char_done = tick && locked_q && !hunt && (cnt_q == fbits - CNT_W'(1));

    bsx_sync_match u_match (
        .hist  (hist_n),
        .fbits (fbits),
        .two   (cfg_two_sync),
        .fr1   (build_frame(cfg_sync1, cfg_len, cfg_par_en, cfg_par_odd)),
        .fr2   (build_frame(cfg_sync2, cfg_len, cfg_par_en, cfg_par_odd)),
        .hit   (hit)
    );

    // bit history and hunt/lock state with character bit count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q   <= '0;
            locked_q <= 1'b0;
            cnt_q    <= '0;
        end else begin
            if (tick) hist_q <= hist_n;
            if (hunt) begin
                locked_q <= 1'b0;
                cnt_q    <= '0;
            end else if (tick) begin
                if (!locked_q) begin
                    if (lock_now) begin
                        locked_q <= 1'b1;
                        cnt_q    <= cfg_ext_sync ? CNT_W'(1) : '0;
                    end
                end else begin
                    cnt_q <= char_done ? '0 : cnt_q + CNT_W'(1);
                end
            end
        end
    end

    // receive holding buffer with parity and overrun status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= '0;
            rdy_q  <= 1'b0;
            perr_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else if (char_done) begin
            buf_q  <= CHAR_MAX'(got & data_mask(cfg_len));
            rdy_q  <= 1'b1;
            perr_q <= cfg_par_en && ((^got) != cfg_par_odd);
            ovr_q  <= !rd && (rdy_q || ovr_q);
        end else if (rd) begin
            rdy_q  <= 1'b0;
            perr_q <= 1'b0;
            ovr_q  <= 1'b0;
        end
    end

    assign rdata  = buf_q;
    assign ready  = rdy_q;
    assign locked = locked_q;
    assign perr   = perr_q;
    assign ovr    = ovr_q;
endmodule

// File: rtl/bisync_xcvr.sv
// Top of the character-synchronous transceiver: joins transmit and receive halves.
// Assumes both tick inputs are single-cycle strobes in the clk domain.
module bisync_xcvr
    import bsx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic                cfg_two_sync,
    input  logic                cfg_ext_sync,
    input  logic [CHAR_MAX-1:0] cfg_sync1,
    input  logic [CHAR_MAX-1:0] cfg_sync2,
    input  logic                tx_tick,
    input  logic                tx_wr,
    input  logic [CHAR_MAX-1:0] tx_wdata,
    output logic                tx_ready,
    output logic                tx_empty,
    output logic                tx_sd,
    input  logic                rx_tick,
    input  logic                rx_sd,
    input  logic                ext_sync,
    input  logic                hunt_cmd,
    input  logic                rx_rd,
    output logic [CHAR_MAX-1:0] rx_rdata,
    output logic                rx_ready,
    output logic                sync_det,
    output logic                par_err,
    output logic                ovr_err
);
    logic rx_char_done;

    bsx_tx u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_len      (cfg_len),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_two_sync (cfg_two_sync),
        .cfg_sync1    (cfg_sync1),
        .cfg_sync2    (cfg_sync2),
        .tick         (tx_tick),
        .wr           (tx_wr),
        .wdata        (tx_wdata),
        .ready        (tx_ready),
        .empty        (tx_empty),
        .sd           (tx_sd)
    );

    bsx_rx u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_len      (cfg_len),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_two_sync (cfg_two_sync),
        .cfg_ext_sync (cfg_ext_sync),
        .cfg_sync1    (cfg_sync1),
        .cfg_sync2    (cfg_sync2),
        .tick         (rx_tick),
        .sd           (rx_sd),
        .ext_sync     (ext_sync),
        .hunt         (hunt_cmd),
        .rd           (rx_rd),
        .rdata        (rx_rdata),
        .ready        (rx_ready),
        .locked       (sync_det),
        .perr         (par_err),
        .ovr          (ovr_err),
        .char_done    (rx_char_done)
    );
endmodule

// File: rtl/bsx_checker.sv
// Temporal checks on the transceiver ports, bound into every instance of the top.
module bsx_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_wr,
    input logic tx_ready,
    input logic rx_tick,
    input logic hunt_cmd,
    input logic rx_rd,
    input logic rx_ready,
    input logic sync_det,
    input logic ovr_err,
    input logic rx_char_done
);
    // R4
    wr_takes_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_ready) |=> !tx_ready);

    // R11
    hunt_drops_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_cmd |=> !sync_det);

    // R11
    lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_det && !hunt_cmd) |=> sync_det);

    // R5
    lock_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_det) |-> $past(rx_tick));

    // R7
    delivery_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(rx_tick));

    // R9
    overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_char_done && rx_ready && !rx_rd) |=> ovr_err);

    // R9
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !rx_char_done) |=> (!rx_ready && !ovr_err));
endmodule

bind bisync_xcvr bsx_checker chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_wr        (tx_wr),
    .tx_ready     (tx_ready),
    .rx_tick      (rx_tick),
    .hunt_cmd     (hunt_cmd),
    .rx_rd        (rx_rd),
    .rx_ready     (rx_ready),
    .sync_det     (sync_det),
    .ovr_err      (ovr_err),
    .rx_char_done (rx_char_done)
);

// File: tb/bisync_xcvr_tb_top.sv
`timescale 1ns/1ps
module bisync_xcvr_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic       cfg_two_sync = 1'b0, cfg_ext_sync = 1'b0;
    logic [7:0] cfg_sync1 = 8'h07, cfg_sync2 = 8'h0D;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_wdata = 8'h00;
    logic       tx_ready, tx_empty, tx_sd;
    logic       ext_sync = 1'b0, hunt_cmd = 1'b0;
    logic [7:0] rx_rdata;
    logic       rx_ready, sync_det, par_err, ovr_err;

    logic man = 1'b1, loop_on = 1'b0, rdr_on = 1'b0;
    logic tick_a = 1'b0, tick_m = 1'b0, rx_b = 1'b1, rd_a = 1'b0, rd_m = 1'b0;
    logic [1:0] div = 2'd0;
    logic tick, rx_sd, rx_rd;
    logic pe_tick = 1'b0, pe_live = 1'b0;

    logic txb [0:511];
    int   n = 0;
    logic [7:0] rxd [0:63];
    logic       rxp [0:63];
    int   m = 0;
    int   checks = 0, fails = 0;
    logic done = 1'b0;

    assign tick  = man ? tick_m : tick_a;
    assign rx_sd = loop_on ? tx_sd : rx_b;
    assign rx_rd = rdr_on ? rd_a : rd_m;

    always #2 clk = ~clk;

    bisync_xcvr dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_two_sync(cfg_two_sync), .cfg_ext_sync(cfg_ext_sync),
        .cfg_sync1(cfg_sync1), .cfg_sync2(cfg_sync2), .tx_tick(tick), .tx_wr(tx_wr),
        .tx_wdata(tx_wdata), .tx_ready(tx_ready), .tx_empty(tx_empty), .tx_sd(tx_sd),
        .rx_tick(tick), .rx_sd(rx_sd), .ext_sync(ext_sync), .hunt_cmd(hunt_cmd),
        .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_ready(rx_ready), .sync_det(sync_det),
        .par_err(par_err), .ovr_err(ovr_err)
    );

    // record what happened at each rising edge
    always @(posedge clk) begin
        pe_tick <= tick;
        pe_live <= rst_n;
    end

    // automatic tick divider and transmit line capture
    always @(negedge clk) begin
        div    <= div + 2'd1;
        tick_a <= (div == 2'd3);
        if (!pe_live) n <= 0;
        else if (pe_tick && !man && n < 512) begin
            txb[n] <= tx_sd;
            n <= n + 1;
        end
    end

    // automatic reader for loopback runs
    always @(negedge clk) begin
        if (!pe_live) begin
            m <= 0;
            rd_a <= 1'b0;
        end else if (rdr_on && rx_ready && !rd_a) begin
            rd_a <= 1'b1;
            if (m < 64) begin
                rxd[m] <= rx_rdata;
                rxp[m] <= par_err;
                m <= m + 1;
            end
        end else rd_a <= 1'b0;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int fbits_of(input int len, input int pe);
        return 5 + len + pe;
    endfunction

    // framed character computed by counting ones
    function automatic logic [8:0] exp_frame(input logic [7:0] d, input int len,
                                             input int pe, input int po);
        logic [8:0] f;
        int ones;
        f = '0;
        ones = 0;
        for (int i = 0; i < 5 + len; i++) begin
            f[i] = d[i];
            ones += int'(d[i]);
        end
        if (pe != 0) f[5 + len] = logic'((ones + po) % 2);
        return f;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_bit(input logic b, input logic e);
        @(negedge clk);
        rx_b = b;
        ext_sync = e;
        tick_m = 1'b1;
        @(negedge clk);
        tick_m = 1'b0;
        ext_sync = 1'b0;
    endtask

    task automatic send_frame(input logic [8:0] f, input int nb, input logic ext_first);
        for (int i = 0; i < nb; i++) send_bit(f[i], ext_first && (i == 0));
    endtask

    task automatic read_pulse();
        @(negedge clk);
        rd_m = 1'b1;
        @(negedge clk);
        rd_m = 1'b0;
    endtask

    // loopback run for one configuration
    task automatic run_cfg(input int len, input int pm, input int two);
        logic [7:0] dat [0:2];
        logic [8:0] f1, f2, fc;
        int nb, di, nc;
        logic exp2;
        dat[0] = 8'hA5; dat[1] = 8'h3C; dat[2] = 8'h6B;
        cfg_len = 2'(len);
        cfg_par_en = (pm != 0);
        cfg_par_odd = (pm == 2);
        cfg_two_sync = logic'(two);
        cfg_ext_sync = 1'b0;
        man = 1'b0; loop_on = 1'b1; rdr_on = 1'b1;
        nb = fbits_of(len, int'(pm != 0));
        do_reset();
        repeat (24 * nb) @(negedge clk);
        chk(tx_empty && tx_ready, "R3 idle fill empty flag", int'(tx_empty), 1);
        for (int k = 0; k < 3; k++) begin
            while (!tx_ready) @(negedge clk);
            tx_wr = 1'b1; tx_wdata = dat[k];
            @(negedge clk);
            tx_wr = 1'b0;
            chk(!tx_ready, "R4 write takes buffer", int'(tx_ready), 0);
            chk(!tx_empty, "R3 empty drops with data", int'(tx_empty), 0);
            if (k == 0) begin
                tx_wr = 1'b1; tx_wdata = 8'hFF;
                @(negedge clk);
                tx_wr = 1'b0;
            end
        end
        repeat (40 * nb) @(negedge clk);
        // decode the transmit line at fixed character offsets
        f1 = exp_frame(cfg_sync1, len, int'(pm != 0), int'(pm == 2));
        f2 = exp_frame(cfg_sync2, len, int'(pm != 0), int'(pm == 2));
        di = 0; exp2 = 1'b0;
        nc = n / nb;
        for (int c = 0; c < nc; c++) begin
            fc = '0;
            for (int b = 0; b < nb; b++) fc[b] = txb[c * nb + b];
            if (exp2) begin
                chk(fc == f2, "R3 second sync follows first", int'(fc), int'(f2));
                exp2 = 1'b0;
            end else if (fc == f1) begin
                exp2 = (two != 0);
                checks++;
            end else if (di < 3) begin
                chk(fc == exp_frame(dat[di], len, int'(pm != 0), int'(pm == 2)),
                    "R1 R2 data character framing", int'(fc),
                    int'(exp_frame(dat[di], len, int'(pm != 0), int'(pm == 2))));
                di++;
            end else chk(1'b0, "R4 unexpected character on line", int'(fc), int'(f1));
        end
        chk(di == 3, "R1 all data characters sent", di, 3);
        // received characters: skip syncs, data in order
        di = 0;
        for (int r = 0; r < m; r++) begin
            chk(!rxp[r], "R8 no parity fault in loopback", int'(rxp[r]), 0);
            if (rxd[r] != (cfg_sync1 & 8'(f1)) && rxd[r] != (cfg_sync2 & 8'(f2)) && di < 3) begin
                chk(rxd[r] == (dat[di] & ((8'd1 << (5 + len)) - 8'd1)), "R7 received data",
                    int'(rxd[r]), int'(dat[di] & ((8'd1 << (5 + len)) - 8'd1)));
                di++;
            end
        end
        chk(di == 3, "R7 all data received", di, 3);
        chk(sync_det, two != 0 ? "R6 two-char lock" : "R5 single-char lock", int'(sync_det), 1);
        chk(!ovr_err, "R9 no overrun with prompt reads", int'(ovr_err), 0);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [8:0] s1, s2, fr;
        // reset state
        man = 1'b1;
        do_reset();
        chk(tx_ready && tx_empty && tx_sd, "R12 transmit reset state",
            int'({tx_ready, tx_empty, tx_sd}), 7);
        chk(!rx_ready && !sync_det && !par_err && !ovr_err, "R12 receive reset state",
            int'({rx_ready, sync_det, par_err, ovr_err}), 0);

        // exhaustive loopback sweep
        for (int len = 0; len < 4; len++)
            for (int pm = 0; pm < 3; pm++)
                for (int two = 0; two < 2; two++)
                    run_cfg(len, pm, two);

        // directed receive: 8 bits, even parity, two sync characters
        man = 1'b1; loop_on = 1'b0; rdr_on = 1'b0;
        cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        cfg_two_sync = 1'b1; cfg_ext_sync = 1'b0;
        do_reset();
        s1 = exp_frame(cfg_sync1, 3, 1, 0);
        s2 = exp_frame(cfg_sync2, 3, 1, 0);
        send_frame(s1, 9, 1'b0);
        chk(!sync_det, "R6 first sync alone no lock", int'(sync_det), 0);
        send_frame(9'h000, 9, 1'b0);
        chk(!sync_det, "R6 broken pair no lock", int'(sync_det), 0);
        send_frame(s1, 9, 1'b0);
        for (int i = 0; i < 8; i++) send_bit(s2[i], 1'b0);
        chk(!sync_det, "R5 no lock before last bit", int'(sync_det), 0);
        send_bit(s2[8], 1'b0);
        chk(sync_det, "R5 R6 lock after pair", int'(sync_det), 1);

        fr = exp_frame(8'h5A, 3, 1, 0);
        send_frame(fr, 9, 1'b0);
        chk(rx_ready && rx_rdata == 8'h5A && !par_err, "R7 character after lock",
            int'(rx_rdata), 'h5A);
        read_pulse();
        chk(!rx_ready, "R9 read clears ready", int'(rx_ready), 0);
        fr = exp_frame(8'h33, 3, 1, 0) ^ 9'h100;
        send_frame(fr, 9, 1'b0);
        chk(par_err && rx_rdata == 8'h33, "R8 parity fault flagged", int'(par_err), 1);
        fr = exp_frame(8'h44, 3, 1, 0);
        send_frame(fr, 9, 1'b0);
        chk(ovr_err && rx_rdata == 8'h44 && !par_err, "R9 overrun replaces data",
            int'({ovr_err, rx_rdata}), 'h144);
        read_pulse();
        chk(!rx_ready && !ovr_err, "R9 read clears overrun", int'({rx_ready, ovr_err}), 0);

        for (int i = 0; i < 30; i++) send_bit(logic'(i % 3 == 0), 1'b0);
        chk(sync_det, "R11 lock holds on arbitrary bits", int'(sync_det), 1);
        @(negedge clk); hunt_cmd = 1'b1;
        @(negedge clk); hunt_cmd = 1'b0;
        chk(!sync_det, "R11 hunt command drops lock", int'(sync_det), 0);
        send_frame(s1, 9, 1'b0);
        chk(!sync_det, "R11 R6 hunting again", int'(sync_det), 0);

        // external sync: 6 bits, odd parity
        cfg_len = 2'd1; cfg_par_odd = 1'b1; cfg_two_sync = 1'b0; cfg_ext_sync = 1'b1;
        do_reset();
        send_frame(exp_frame(cfg_sync1, 1, 1, 1), 7, 1'b0);
        chk(!sync_det, "R10 pattern ignored in external mode", int'(sync_det), 0);
        fr = exp_frame(8'h2A, 1, 1, 1);
        send_bit(fr[0], 1'b1);
        chk(sync_det, "R10 external lock", int'(sync_det), 1);
        for (int i = 1; i < 7; i++) send_bit(fr[i], 1'b0);
        chk(rx_ready && rx_rdata == 8'h2A && !par_err, "R10 first character after external lock",
            int'(rx_rdata), 'h2A);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule